// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit virtual addresses into 30-bit physical addresses with a small, fully associative array of cached translations. Pages are 4 KB. The low twelve address bits pass through unchanged, and the upper twenty bits form the virtual page number. That page number is compared against every stored tag in the same cycle as the request.

A hit returns the 18-bit physical page joined to the untouched offset. It also reports the stored reference and dirty bits of the matching entry. The entry's reference bit is set at the next clock edge, and a write also marks the entry dirty.

A miss is flagged to the processor and to the page table walker. The walker then either delivers a refill entry or reports that the page is not resident, which the block forwards as a fault. The access is reissued after a refill. Refills choose their victim in this order:

1. An invalid slot.
2. A slot whose reference bit is clear.
3. When every slot has been referenced, all reference bits are cleared and a rotating pointer picks the victim.

A synchronous flush invalidates the whole array at once.

Top module: `xlat_lookaside`

## Requirements
- R1: On a hit, `paddr` equals the stored 18-bit physical page in bits 29:12 and `req_vaddr[11:0]` in bits 11:0; the virtual page number is `req_vaddr[31:12]`.
- R2: `hit` is 1 only when `req_valid` is 1 and a valid entry's tag equals the virtual page number; `miss` is 1 when `req_valid` is 1 and no such entry exists; both are 0 when `req_valid` is 0.
- R3: On a hit, `hit_ref` shows the entry's reference bit before the access, and the entry's reference bit is 1 from the next clock edge.
- R4: A hit with `req_write` = 1 sets the entry's dirty bit at the next edge, and `hit_dirty` shows it on later hits; a read hit leaves the dirty bit unchanged.
- R5: A refill (`fill_valid` = 1) whose page is not already present goes into the lowest-index invalid entry when one exists; a refilled entry starts with reference bit 0 and dirty bit 0.
- R6: When all entries are valid and at least one has reference bit 0, a refill replaces the lowest-index entry with reference bit 0.
- R7: When all entries are valid and referenced, a refill clears every reference bit and replaces the entry at a rotating pointer; the pointer is 0 after reset and advances by one (wrapping) after each such refill.
- R8: A refill whose virtual page already matches a valid entry overwrites that entry and evicts no other.
- R9: `flush` invalidates every entry at the next edge; a refill in the same cycle as a flush is discarded.
- R10: `fault` is 1 when `walk_fault` is 1 while a miss is pending; a miss sets the pending state at the next edge, and a refill or `walk_fault` clears it.
- R11: After reset every entry is invalid, no miss is pending, and the rotating pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 32 | Virtual address |
| hit | output | 1 | Translation found |
| miss | output | 1 | Translation not found |
| paddr | output | 30 | Physical address on a hit, 0 otherwise |
| hit_ref | output | 1 | Reference bit of the matched entry before this access |
| hit_dirty | output | 1 | Dirty bit of the matched entry before this access |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_vpn | input | 20 | Virtual page of the refill |
| fill_ppn | input | 18 | Physical page of the refill |
| walk_fault | input | 1 | Walker found the page not resident |
| fault | output | 1 | Page fault for the pending miss |

## Verification
The bench fills all sixteen slots and then sweeps every resident page with several offsets, followed by sixteen absent pages. This separates the tag compare from the offset pass-through and from the valid gating. Repeated sweeps with reads and even-slot writes show that the reference bit rises only after the first touch, and that only stores make an entry dirty. The bench then refills a full array in three reference patterns: all referenced, a partial set, and all referenced again. These show which slot each victim rule picks, because the evicted page is the only one that starts missing. A duplicate-page refill, a flush colliding with a refill, and walker faults with and without a pending miss cover the remaining orderings.

// File: rtl/xlat_lookaside.sv
module xlat_lookaside #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFF_W   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            hit,
  output logic            miss,
  output logic [PA_W-1:0] paddr,
  output logic            hit_ref,
  output logic            hit_dirty,
  input  logic            fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic            walk_fault,
  output logic            fault
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, ref_q, dty_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;
  logic               pend_q;

  logic [VPN_W-1:0]   req_vpn;
  logic [ENTRIES-1:0] match, fmatch;
  logic [IDX_W-1:0]   hit_idx, dup_idx, free_idx, cold_idx, victim;
  logic               any_hit, sweep;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i]  = vld_q[i] && (tag_q[i] == req_vpn);
    assign fmatch[i] = vld_q[i] && (tag_q[i] == fill_vpn);
  end

  always_comb begin
    hit_idx  = '0;
    dup_idx  = '0;
    free_idx = '0;
    cold_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])  hit_idx  = IDX_W'(i);
      if (fmatch[i]) dup_idx  = IDX_W'(i);
      if (!vld_q[i]) free_idx = IDX_W'(i);
      if (!ref_q[i]) cold_idx = IDX_W'(i);
    end
  end

  assign any_hit   = |match;
  assign hit       = req_valid && any_hit;
  assign miss      = req_valid && !any_hit;
  assign paddr     = hit ? {ppn_q[hit_idx], req_vaddr[OFF_W-1:0]} : '0;
  assign hit_ref   = hit && ref_q[hit_idx];
  assign hit_dirty = hit && dty_q[hit_idx];
  assign fault     = pend_q && walk_fault;

  assign sweep  = !(|fmatch) && (&vld_q) && (&ref_q);
  assign victim = (|fmatch)   ? dup_idx  :
                  !(&vld_q)   ? free_idx :
                  !(&ref_q)   ? cold_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      ref_q  <= '0;
      dty_q  <= '0;
      rr_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (fill_valid || walk_fault) pend_q <= 1'b0;
      else if (miss)                pend_q <= 1'b1;
      if (flush) begin
        vld_q <= '0;
      end else begin
        if (fill_valid && sweep) begin
          ref_q <= '0;
          rr_q  <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
        if (hit) begin
          ref_q[hit_idx] <= 1'b1;
          if (req_write) dty_q[hit_idx] <= 1'b1;
        end
        if (fill_valid) begin
          vld_q[victim] <= 1'b1;
          ref_q[victim] <= 1'b0;
          dty_q[victim] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && fill_valid) begin
      tag_q[victim] <= fill_vpn;
      ppn_q[victim] <= fill_ppn;
    end
  end

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R3
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !fill_valid && !flush |=> ref_q[$past(hit_idx)]);

  // R4
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && req_write && !fill_valid && !flush |=> dty_q[$past(hit_idx)]);

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld_q == '0);

  // R5
  fill_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !flush |=> vld_q[$past(victim)] && !ref_q[$past(victim)]
                             && tag_q[$past(victim)] == $past(fill_vpn));

  // R10
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !pend_q);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !hit && !miss && paddr == '0);
endmodule

// File: tb/sim_xlat_lookaside.sv
module sim_xlat_lookaside;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic hit, miss, hit_ref, hit_dirty, fault;
  logic [29:0] paddr;
  logic fill_valid = 1'b0, walk_fault = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  int checks = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlat_lookaside u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_write(req_write), .req_vaddr(req_vaddr), .hit(hit), .miss(miss), .paddr(paddr),
    .hit_ref(hit_ref), .hit_dirty(hit_dirty), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .walk_fault(walk_fault), .fault(fault));

  function automatic logic [19:0] va_of(int k); return 20'h10000 + 20'(k * 37); endfunction
  function automatic logic [17:0] pa_of(int k); return 18'(k * 913 + 7); endfunction
  function automatic logic [19:0] vn_of(int j); return 20'hA0000 + 20'(j * 101); endfunction
  function automatic logic [17:0] pn_of(int j); return 18'h20000 + 18'(j * 3); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic look(logic [19:0] vpn, logic [11:0] off, bit wr, bit eh,
                      logic [17:0] eppn, bit st, bit eref, bit edty, string tag);
    @(negedge clk);
    fill_valid = 0; flush = 0;
    req_valid = 1; req_write = wr; req_vaddr = {vpn, off};
    #1;
    chk({tag, " R2 hit"}, 32'(hit), 32'(eh));
    chk({tag, " R2 miss"}, 32'(miss), 32'(!eh));
    if (eh) chk({tag, " R1 paddr"}, 32'(paddr), 32'({eppn, off}));
    if (eh && st) begin
      chk({tag, " R3 ref"}, 32'(hit_ref), 32'(eref));
      chk({tag, " R4 dirty"}, 32'(hit_dirty), 32'(edty));
    end
  endtask

  task automatic fill(logic [19:0] vpn, logic [17:0] ppn, bit fl);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; flush = fl;
    @(negedge clk);
    fill_valid = 0; flush = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 idle hit", 32'(hit), 0);
    chk("R11 idle fault", 32'(fault), 0);
    look(va_of(0), 12'h123, 0, 0, 0, 0, 0, 0, "R11 empty");
    // R5 fill every slot in order
    for (int k = 0; k < 16; k++) fill(va_of(k), pa_of(k), 0);
    for (int k = 0; k < 16; k++)
      look(va_of(k), 12'((k * 257 + 3) & 12'hFFF), 0, 1, pa_of(k), 1, 0, 0, "R5 first");
    for (int k = 0; k < 16; k++)
      look(vn_of(k + 20), 12'(k), 0, 0, 0, 0, 0, 0, "R2 absent");
    for (int k = 0; k < 16; k++)
      look(va_of(k), 12'(12'hFFF - k), (k % 2) == 0, 1, pa_of(k), 1, 1, 0, "R3 second");
    for (int k = 0; k < 16; k++)
      look(va_of(k), 12'h000, 0, 1, pa_of(k), 1, 1, (k % 2) == 0, "R4 after write");
    // R7 all referenced: slot 0 replaced, refs cleared
    fill(vn_of(0), pn_of(0), 0);
    look(va_of(0), 12'h001, 0, 0, 0, 0, 0, 0, "R7 evict0");
    look(vn_of(0), 12'h002, 0, 1, pn_of(0), 1, 0, 0, "R7 new0");
    look(va_of(1), 12'h003, 0, 1, pa_of(1), 1, 0, 0, "R7 cleared");
    // R6 slots 0,1 referenced: slot 2 replaced
    fill(vn_of(1), pn_of(1), 0);
    look(va_of(2), 12'h004, 0, 0, 0, 0, 0, 0, "R6 evict2");
    look(vn_of(1), 12'h005, 0, 1, pn_of(1), 1, 0, 0, "R6 new1");
    for (int k = 3; k < 16; k++)
      look(va_of(k), 12'(k * 11), 0, 1, pa_of(k), 1, 0, (k % 2) == 0, "R6 keep");
    // R7 pointer advanced to slot 1
    fill(vn_of(2), pn_of(2), 0);
    look(va_of(1), 12'h006, 0, 0, 0, 0, 0, 0, "R7 evict1");
    look(vn_of(2), 12'h007, 0, 1, pn_of(2), 1, 0, 0, "R7 new2");
    look(vn_of(0), 12'h008, 0, 1, pn_of(0), 1, 0, 0, "R7 ref cleared0");
    // R8 duplicate refill overwrites in place
    fill(vn_of(2), 18'h3ABCD, 0);
    look(vn_of(2), 12'hABC, 0, 1, 18'h3ABCD, 1, 0, 0, "R8 overwrite");
    look(vn_of(1), 12'h009, 0, 1, pn_of(1), 0, 0, 0, "R8 neighbour");
    for (int k = 3; k < 16; k++)
      look(va_of(k), 12'(k), 0, 1, pa_of(k), 0, 0, 0, "R8 intact");
    // R9 flush beats simultaneous refill
    fill(vn_of(9), pn_of(9), 1);
    look(vn_of(9), 12'h00A, 0, 0, 0, 0, 0, 0, "R9 fill dropped");
    for (int k = 3; k < 16; k++)
      look(va_of(k), 12'(k), 0, 0, 0, 0, 0, 0, "R9 flushed");
    look(vn_of(0), 12'h00B, 0, 0, 0, 0, 0, 0, "R9 flushed new");
    // R10 fault only with a pending miss
    @(negedge clk);
    req_valid = 0; walk_fault = 1;
    #1 chk("R10 fault pending", 32'(fault), 1);
    @(negedge clk);
    #1 chk("R10 fault cleared", 32'(fault), 0);
    walk_fault = 0;
    look(vn_of(5), 12'h00C, 0, 0, 0, 0, 0, 0, "R10 miss");
    fill(vn_of(5), pn_of(5), 0);
    walk_fault = 1;
    #1 chk("R10 no fault after fill", 32'(fault), 0);
    walk_fault = 0;
    look(vn_of(5), 12'h00D, 0, 1, pn_of(5), 1, 0, 0, "R5 after flush");
    @(negedge clk);
    req_valid = 0;
    #1 chk("R2 idle", 32'({hit, miss}), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule